// File: doc/BRIEF.md
# Transactional Memory Reservation Buffer

This block gives a processor a small hardware transaction facility. A start pulse opens a speculative region. Inside it, every tagged load and tagged store claims one of a fixed number of reservation slots. A load records its address and returns data. A store keeps its data inside the buffer, so shared memory and other agents cannot see it yet. A load that hits a buffered store gets the buffered value back.

A commit pulse closes the region. With no conflict, the block requests the shared-memory lock. Once the grant arrives, it writes every buffered store in one uninterrupted burst while it keeps the lock. A conflict discards everything. A conflict is a write by another agent, seen on the snoop port, to any reserved address, or an access that needs more slots than exist. On a conflict the block raises the fail flag and pulses two outputs, one asking for a register restore and one asking for a branch back to the region start. The processor carries out both; this block does not. After a commit or an abort, all slots are empty and the block waits for the next start.

Top module: `tmrb_top`

## Requirements
- R1: During and right after reset, the block is outside any region: tx_active_o, tx_fail_o, mem_lock_o, mem_we_o, commit_done_o, retry_o and restore_o are all 0.
- R2: A start pulse while idle raises tx_active_o and clears tx_fail_o from the next clock edge.
- R3: A tagged store inside a region writes nothing to memory before commit. A later load of the same address returns the buffered data. A load of an address with no buffered store returns mem_rd_data_i.
- R4: A commit with buffered stores raises mem_lock_o. Once mem_gnt_i is seen, the block writes each buffered store once, one per cycle, in slot allocation order, with mem_lock_o high on every write cycle. It then gives a one-cycle commit_done_o and returns to idle. A commit with no buffered store gives commit_done_o on the next edge and never raises mem_lock_o.
- R5: With SLOTS reservations (default 4), an access to a new address when all slots are used aborts the transaction.
- R6: A snoop write whose address matches any reserved address, whether from a load or a store, aborts the transaction. A snoop to an address that is not reserved has no effect.
- R7: A matching snoop in the same cycle as commit wins. The transaction aborts and no memory write occurs.
- R8: An abort sets tx_fail_o, pulses retry_o and restore_o for exactly one cycle, drops tx_active_o, discards every buffered store without writing it, and returns to idle.
- R9: After a commit or an abort, all slots are free, so the next transaction can again reserve SLOTS distinct addresses.
- R10: Accesses and commit pulses given while idle are ignored. They record nothing, write nothing and give no commit_done_o.
- R11: Repeated accesses to one address share one slot. A store to an address that was only loaded turns that slot into a store slot holding the latest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start_i | input | 1 | Open a speculative region (pulse) |
| tx_commit_i | input | 1 | Close the region and publish (pulse) |
| acc_valid_i | input | 1 | Tagged access this cycle |
| acc_write_i | input | 1 | 1 = tagged store, 0 = tagged load |
| acc_addr_i | input | AW | Access address |
| acc_wdata_i | input | DW | Store data |
| acc_rdata_o | output | DW | Load data, buffered value or memory value |
| mem_rd_addr_o | output | AW | Shared-memory read address |
| mem_rd_data_i | input | DW | Shared-memory read data, same cycle |
| snoop_valid_i | input | 1 | Another agent writes this cycle |
| snoop_addr_i | input | AW | Address written by the other agent |
| mem_lock_o | output | 1 | Request and hold the shared-memory lock |
| mem_gnt_i | input | 1 | Lock granted |
| mem_we_o | output | 1 | Shared-memory write strobe |
| mem_waddr_o | output | AW | Shared-memory write address |
| mem_wdata_o | output | DW | Shared-memory write data |
| tx_active_o | output | 1 | Region open or publication in progress |
| tx_fail_o | output | 1 | Last transaction aborted; cleared by start |
| restore_o | output | 1 | One-cycle register restore request |
| retry_o | output | 1 | One-cycle branch-to-start request |
| commit_done_o | output | 1 | One-cycle pulse after a successful commit |

## Verification
The hardest cases to reach are a snoop that arrives in the very cycle of commit, and a publication that waits for a late grant. Both need an exact alignment between the region state and the bus inputs. The bench drives commit and a matching snoop on the same falling edge. It also holds the grant low for several cycles after commit while it watches that the lock stays high and no store leaks out. A memory model in the bench records the order of the writes, so it can confirm the slot order, that loads are skipped during the burst, and that no write appears early.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_ACQ    = 2'd2,
    ST_BURST  = 2'd3
  } tm_state_e;
endpackage

// File: rtl/tmrb_slot_array.sv
module tmrb_slot_array #(
  parameter int SLOTS = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(SLOTS + 1),
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          rec_en_i,
  input  logic          rec_write_i,
  input  logic [AW-1:0] rec_addr_i,
  input  logic [DW-1:0] rec_wdata_i,
  input  logic          snoop_valid_i,
  input  logic [AW-1:0] snoop_addr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          fwd_hit_o,
  output logic [DW-1:0] fwd_data_o,
  output logic          snoop_hit_o,
  output logic          full_miss_o,
  output logic          any_store_o,
  output logic [CW-1:0] used_o,
  output logic          rd_store_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_data_o
);

  logic [SLOTS-1:0] vld_q, vld_d, st_q, st_d, match, snp;
  logic [AW-1:0]    addr_q [SLOTS];
  logic [AW-1:0]    addr_d [SLOTS];
  logic [DW-1:0]    data_q [SLOTS];
  logic [DW-1:0]    data_d [SLOTS];
  logic [CW-1:0]    used_q, used_d;
  logic             hit_any, is_full, alloc;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (addr_q[i] == rec_addr_i);
    assign snp[i]   = vld_q[i] && (addr_q[i] == snoop_addr_i);
  end

  assign hit_any     = |match;
  assign is_full     = (used_q == CW'(SLOTS));
  assign alloc       = rec_en_i && !hit_any && !is_full;
  assign full_miss_o = !hit_any && is_full;
  assign snoop_hit_o = snoop_valid_i && (|snp);
  assign any_store_o = |(vld_q & st_q);
  assign used_o      = used_q;

  always_comb begin
    fwd_hit_o  = 1'b0;
    fwd_data_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i] && st_q[i]) begin
        fwd_hit_o  = 1'b1;
        fwd_data_o = data_q[i];
      end
    end
  end

  always_comb begin
    rd_store_o = 1'b0;
    rd_addr_o  = '0;
    rd_data_o  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rd_idx_i == IW'(i)) begin
        rd_store_o = vld_q[i] && st_q[i];
        rd_addr_o  = addr_q[i];
        rd_data_o  = data_q[i];
      end
    end
  end

  // next-state for the slots
  always_comb begin
    vld_d  = vld_q;
    st_d   = st_q;
    addr_d = addr_q;
    data_d = data_q;
    used_d = used_q;
    if (clear_i) begin
      vld_d  = '0;
      st_d   = '0;
      used_d = '0;
    end else begin
      if (alloc) used_d = used_q + CW'(1);
      for (int i = 0; i < SLOTS; i++) begin
        if (alloc && (used_q == CW'(i))) begin
          vld_d[i]  = 1'b1;
          st_d[i]   = rec_write_i;
          addr_d[i] = rec_addr_i;
          data_d[i] = rec_wdata_i;
        end else if (rec_en_i && match[i] && rec_write_i) begin
          st_d[i]   = 1'b1;
          data_d[i] = rec_wdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      st_q   <= '0;
      used_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      vld_q  <= vld_d;
      st_q   <= st_d;
      used_q <= used_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  AST_ONE_SLOT_PER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1); // R11
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(SLOTS)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (used_q == '0) && (vld_q == '0)); // R9

endmodule

// File: rtl/tmrb_ctrl.sv
module tmrb_ctrl
  import tmrb_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CW   = $clog2(SLOTS + 1),
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          commit_i,
  input  logic          acc_valid_i,
  input  logic          snoop_hit_i,
  input  logic          full_miss_i,
  input  logic          any_store_i,
  input  logic [CW-1:0] used_i,
  input  logic          mem_gnt_i,
  output logic          rec_en_o,
  output logic          clear_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          burst_o,
  output logic          mem_lock_o,
  output logic          tx_active_o,
  output logic          fail_o,
  output logic          abort_o,
  output logic          done_o
);

  tm_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          fail_q, fail_d, abort_q, abort_d, done_q, done_d;
  logic          last_slot;

  assign last_slot = ((CW'(idx_q) + CW'(1)) == used_i);

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    fail_d   = fail_q;
    abort_d  = 1'b0;
    done_d   = 1'b0;
    clear_o  = 1'b0;
    rec_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ACTIVE;
          fail_d = 1'b0;
        end
      end
      ST_ACTIVE: begin
        if (snoop_hit_i || (acc_valid_i && full_miss_i)) begin
          st_d    = ST_IDLE;
          fail_d  = 1'b1;
          abort_d = 1'b1;
          clear_o = 1'b1;
        end else if (commit_i) begin
          if (any_store_i) begin
            st_d = ST_ACQ;
          end else begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            clear_o = 1'b1;
          end
        end else begin
          rec_en_o = acc_valid_i;
        end
      end
      ST_ACQ: begin
        if (snoop_hit_i) begin
          st_d    = ST_IDLE;
          fail_d  = 1'b1;
          abort_d = 1'b1;
          clear_o = 1'b1;
        end else if (mem_gnt_i) begin
          st_d  = ST_BURST;
          idx_d = '0;
        end
      end
      ST_BURST: begin
        if (last_slot) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          clear_o = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      abort_q <= abort_d;
      done_q  <= done_d;
    end
  end

  assign rd_idx_o    = idx_q;
  assign burst_o     = (st_q == ST_BURST);
  assign mem_lock_o  = (st_q == ST_ACQ) || (st_q == ST_BURST);
  assign tx_active_o = (st_q != ST_IDLE);
  assign fail_o      = fail_q;
  assign abort_o     = abort_q;
  assign done_o      = done_q;

  AST_START_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i) |=> !fail_q); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_SNOOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && snoop_hit_i) |=> (abort_q && fail_q)); // R6
  AST_SNOOP_BEATS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTIVE && commit_i && snoop_hit_i) |=> (st_q == ST_IDLE && !done_q)); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q); // R8

endmodule

// File: rtl/tmrb_top.sv
module tmrb_top #(
  parameter int SLOTS = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start_i,
  input  logic          tx_commit_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] acc_rdata_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [DW-1:0] mem_rd_data_i,
  input  logic          snoop_valid_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          mem_lock_o,
  input  logic          mem_gnt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          tx_active_o,
  output logic          tx_fail_o,
  output logic          restore_o,
  output logic          retry_o,
  output logic          commit_done_o
);

  localparam int CW = $clog2(SLOTS + 1);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic          rec_en, clear, fwd_hit, snoop_hit, full_miss, any_store;
  logic          burst, rd_store, abort;
  logic [DW-1:0] fwd_data;
  logic [CW-1:0] used;
  logic [IW-1:0] rd_idx;

  tmrb_slot_array #(.SLOTS(SLOTS), .AW(AW), .DW(DW)) u_slots (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear),
    .rec_en_i      (rec_en),
    .rec_write_i   (acc_write_i),
    .rec_addr_i    (acc_addr_i),
    .rec_wdata_i   (acc_wdata_i),
    .snoop_valid_i (snoop_valid_i),
    .snoop_addr_i  (snoop_addr_i),
    .rd_idx_i      (rd_idx),
    .fwd_hit_o     (fwd_hit),
    .fwd_data_o    (fwd_data),
    .snoop_hit_o   (snoop_hit),
    .full_miss_o   (full_miss),
    .any_store_o   (any_store),
    .used_o        (used),
    .rd_store_o    (rd_store),
    .rd_addr_o     (mem_waddr_o),
    .rd_data_o     (mem_wdata_o)
  );

  tmrb_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (tx_start_i),
    .commit_i    (tx_commit_i),
    .acc_valid_i (acc_valid_i),
    .snoop_hit_i (snoop_hit),
    .full_miss_i (full_miss),
    .any_store_i (any_store),
    .used_i      (used),
    .mem_gnt_i   (mem_gnt_i),
    .rec_en_o    (rec_en),
    .clear_o     (clear),
    .rd_idx_o    (rd_idx),
    .burst_o     (burst),
    .mem_lock_o  (mem_lock_o),
    .tx_active_o (tx_active_o),
    .fail_o      (tx_fail_o),
    .abort_o     (abort),
    .done_o      (commit_done_o)
  );

  assign mem_rd_addr_o = acc_addr_i;
  assign acc_rdata_o   = fwd_hit ? fwd_data : mem_rd_data_i;
  assign mem_we_o      = burst && rd_store;
  assign restore_o     = abort;
  assign retry_o       = abort;

  AST_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(mem_lock_o)); // R4
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> (!mem_we_o && !tx_active_o)); // R8
  AST_IDLE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active_o |-> !mem_lock_o); // R10

endmodule

// File: tb/tmrb_top_tb.sv
module tmrb_top_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_start, tx_commit, acc_valid, acc_write;
  logic [AW-1:0] acc_addr, snoop_addr;
  logic [DW-1:0] acc_wdata, acc_rdata, mem_rd_data, mem_wdata;
  logic [AW-1:0] mem_rd_addr, mem_waddr;
  logic          snoop_valid, mem_lock, mem_gnt, mem_we;
  logic          tx_active, tx_fail, restore, retry, done;

  logic [DW-1:0] shmem [2**AW];
  logic [AW-1:0] wr_log [16];
  int            wr_cnt = 0;
  int            unlocked_wr = 0;
  int            total = 0;
  int            bad = 0;
  int            cyc = 0;

  always #10 clk = ~clk;

  tmrb_top #(.SLOTS(4), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start_i(tx_start), .tx_commit_i(tx_commit),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_data_i(mem_rd_data), .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .mem_lock_o(mem_lock), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata), .tx_active_o(tx_active),
    .tx_fail_o(tx_fail), .restore_o(restore), .retry_o(retry), .commit_done_o(done)
  );

  assign mem_rd_data = shmem[mem_rd_addr];

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 7 + 3);
  endfunction

  // shared-memory model
  always @(posedge clk) begin
    if (mem_we) begin
      shmem[mem_waddr] = mem_wdata;
      if (wr_cnt < 16) wr_log[wr_cnt] = mem_waddr;
      wr_cnt = wr_cnt + 1;
      if (!mem_lock) unlocked_wr = unlocked_wr + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_tx();
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic commit_tx();
    tx_commit = 1'b1;
    @(negedge clk);
    tx_commit = 1'b0;
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd);
    acc_valid = 1'b1;
    acc_write = w;
    acc_addr  = a;
    acc_wdata = d;
    #2;
    rd = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    snoop_valid = 1'b1;
    snoop_addr  = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 40) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // fields: [40] write, [39:32] addr, [31:16] wdata, [15:0] expected load data
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 8'h10, 16'h0000, 16'h0073},
    {1'b1, 8'h20, 16'hA5A5, 16'h0000},
    {1'b0, 8'h20, 16'h0000, 16'hA5A5},
    {1'b1, 8'h10, 16'h1234, 16'h0000},
    {1'b0, 8'h10, 16'h0000, 16'h1234},
    {1'b1, 8'h30, 16'hBEEF, 16'h0000},
    {1'b0, 8'h40, 16'h0000, 16'h01C3},
    {1'b1, 8'h20, 16'h5555, 16'h0000}
  };

  initial begin
    logic [DW-1:0] rd;
    int n, w0;
    for (int a = 0; a < 2**AW; a++) shmem[a] = init_val(a);
    rst_n = 1'b0; tx_start = 0; tx_commit = 0; acc_valid = 0; acc_write = 0;
    acc_addr = '0; acc_wdata = '0; snoop_valid = 0; snoop_addr = '0; mem_gnt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 active in reset", int'(tx_active), 0);
    chk("R1 lock in reset", int'(mem_lock), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset",
        int'({tx_active, tx_fail, mem_lock, mem_we, done, retry, restore}), 0);

    // vector table: one transaction mixing loads, stores and forwarding
    start_tx();
    chk("R2 active after start", int'(tx_active), 1);
    for (int i = 0; i < 8; i++) begin
      access(VEC[i][40], VEC[i][39:32], VEC[i][31:16], rd);
      if (!VEC[i][40]) chk($sformatf("R3 load data vec %0d", i), int'(rd), int'(VEC[i][15:0]));
    end
    chk("R11 no overflow with repeated addresses", int'(tx_fail), 0);
    chk("R3 no write before commit", wr_cnt, 0);
    chk("R3 memory 0x20 untouched", int'(shmem[8'h20]), int'(init_val(8'h20)));
    commit_tx();
    wait_done(n);
    chk("R4 commit done seen", int'(done), 1);
    chk("R4 three stores written", wr_cnt, 3);
    chk("R4 write order slot0", int'(wr_log[0]), 8'h10);
    chk("R4 write order slot1", int'(wr_log[1]), 8'h20);
    chk("R4 write order slot2", int'(wr_log[2]), 8'h30);
    chk("R11 latest data 0x10", int'(shmem[8'h10]), 16'h1234);
    chk("R11 latest data 0x20", int'(shmem[8'h20]), 16'h5555);
    chk("R4 data 0x30", int'(shmem[8'h30]), 16'hBEEF);
    chk("R4 loaded 0x40 not written", int'(shmem[8'h40]), int'(init_val(8'h40)));
    chk("R4 writes under lock", unlocked_wr, 0);
    @(negedge clk);
    chk("R4 done is one cycle", int'(done), 0);
    chk("R4 idle after commit", int'({tx_active, mem_lock, tx_fail}), 0);

    // late grant
    mem_gnt = 1'b0;
    w0 = wr_cnt;
    start_tx();
    access(1'b1, 8'h50, 16'h0101, rd);
    commit_tx();
    repeat (3) @(negedge clk);
    chk("R4 lock held while waiting grant", int'(mem_lock), 1);
    chk("R4 no write before grant", wr_cnt - w0, 0);
    mem_gnt = 1'b1;
    wait_done(n);
    chk("R4 write after grant", wr_cnt - w0, 1);
    chk("R4 late grant data", int'(shmem[8'h50]), 16'h0101);
    @(negedge clk);

    // commit with loads only
    w0 = wr_cnt;
    start_tx();
    access(1'b0, 8'h60, '0, rd);
    commit_tx();
    chk("R4 load-only commit done next edge", int'(done), 1);
    chk("R4 load-only commit no lock", int'(mem_lock), 0);
    chk("R4 load-only commit no write", wr_cnt - w0, 0);
    @(negedge clk);

    // overflow
    start_tx();
    for (int i = 0; i < 4; i++) access(1'b0, AW'(8'h70 + i), '0, rd);
    chk("R5 four slots no fail", int'(tx_fail), 0);
    access(1'b0, 8'h74, '0, rd);
    chk("R5 fifth address aborts", int'(tx_fail), 1);
    chk("R8 retry pulse", int'(retry), 1);
    chk("R8 restore pulse", int'(restore), 1);
    chk("R8 inactive after abort", int'(tx_active), 0);
    @(negedge clk);
    chk("R8 retry one cycle", int'({retry, restore}), 0);

    // start clears fail; slots free after abort
    start_tx();
    chk("R2 start clears fail", int'(tx_fail), 0);
    for (int i = 0; i < 4; i++) access(1'b0, AW'(8'hC0 + i), '0, rd);
    chk("R9 four slots free after abort", int'(tx_fail), 0);
    commit_tx();
    @(negedge clk);
    start_tx();
    for (int i = 0; i < 4; i++) access(1'b0, AW'(8'hC8 + i), '0, rd);
    chk("R9 four slots free after commit", int'({tx_fail, tx_active}), 1);
    commit_tx();
    @(negedge clk);

    // snoop on load reservation, and a snoop miss
    start_tx();
    access(1'b0, 8'h80, '0, rd);
    snoop(8'h81);
    chk("R6 snoop miss no effect", int'({tx_active, tx_fail}), 2);
    snoop(8'h80);
    chk("R6 snoop on load aborts", int'({tx_active, tx_fail}), 1);
    @(negedge clk);

    // snoop on store reservation
    w0 = wr_cnt;
    start_tx();
    access(1'b1, 8'h90, 16'h7777, rd);
    snoop(8'h90);
    chk("R6 snoop on store aborts", int'(tx_fail), 1);
    repeat (3) @(negedge clk);
    chk("R8 discarded store not written", int'(shmem[8'h90]), int'(init_val(8'h90)));
    chk("R8 no writes on abort", wr_cnt - w0, 0);

    // snoop in the commit cycle
    w0 = wr_cnt;
    start_tx();
    access(1'b1, 8'hA0, 16'h4242, rd);
    tx_commit = 1'b1; snoop_valid = 1'b1; snoop_addr = 8'hA0;
    @(negedge clk);
    tx_commit = 1'b0; snoop_valid = 1'b0;
    chk("R7 snoop beats commit", int'({tx_fail, mem_lock, done}), 4);
    repeat (4) @(negedge clk);
    chk("R7 no write", wr_cnt - w0, 0);
    chk("R7 memory unchanged", int'(shmem[8'hA0]), int'(init_val(8'hA0)));

    // idle accesses and commit ignored
    w0 = wr_cnt;
    access(1'b1, 8'hB0, 16'h9999, rd);
    commit_tx();
    chk("R10 idle commit no done", int'({done, tx_active, mem_lock}), 0);
    start_tx();
    access(1'b0, 8'hB0, '0, rd);
    chk("R10 idle store not buffered", int'(rd), int'(init_val(8'hB0)));
    commit_tx();
    chk("R10 empty commit done", int'(done), 1);
    repeat (3) @(negedge clk);
    chk("R10 idle store never written", wr_cnt - w0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule